// File: doc/BRIEF.md
# Inclusion-Bit Snoop Forwarding Filter

This block keeps a small direct-mapped directory for a second-level cache. Each entry holds a valid flag, a tag and one presence flag per 32-byte granule of the line. A presence flag records that the first-level cache may hold that granule. Processor-side operations keep the flags current. A read allocates the entry, or replaces it, and sets the flag of the granule it reads. Three deallocating operations clear the flag of their granule: a write-with-kill (a castout, or a snoop response that leaves the L1 copy invalid), a data-cache block kill, and an instruction-cache block invalidate.

A system-bus snoop goes to the processor only when it hits the directory and the flag of its granule is set. A snoop that misses, or that finds a clear flag, is absorbed. Reads never clear flags, even when they push a line out of the L1, so the flags can overstate what the L1 holds. The cost of that is an occasional needless forward, never a missed one. After each directory write the block reports the new flag vector of the written set. Data movement and back-invalidation are handled outside this block.

Top module: `ifb_snoop_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `fwd_o` and `upd_valid_o` are 0, and every directory entry is invalid, so a first snoop is not forwarded.
- R2: A read operation (code 1) sets the flag of its granule one cycle later, with `upd_valid_o`=1, `upd_index_o` equal to the set index and `upd_bits_o` equal to the new flag vector. If the entry was invalid or held a different tag, the tag is replaced and only that granule's flag is set.
- R3: A write-with-kill (code 2) that hits the directory clears its granule's flag, and the update is reported one cycle later.
- R4: A block kill (code 3) that hits the directory clears its granule's flag.
- R5: An instruction block invalidate (code 4) that hits the directory clears its granule's flag.
- R6: A read to a line whose tag matches leaves the flags of the other granules of that line unchanged.
- R7: A snoop whose set is invalid or whose tag differs from the stored tag is not forwarded.
- R8: A snoop that hits a granule whose flag is clear is not forwarded.
- R9: A snoop that hits a granule whose flag is set raises `fwd_o` for exactly one cycle, one cycle after the snoop, with `fwd_addr_o` equal to the snooped address.
- R10: A clearing operation (codes 2, 3 or 4) that misses the directory gives `upd_valid_o`=0 and changes no flag.
- R11: When a clear and a snoop to the same granule arrive in the same cycle, the snoop decision uses the flag value from before the clear.
- R12: Address bits [4:0] select a byte inside a granule and play no part in the decision. Bits [6:5] select the granule, bits [10:7] the set, and bits [31:11] form the tag (default parameters). Code 0 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Processor operation: 0 none, 1 read, 2 write-with-kill, 3 block kill, 4 instruction block invalidate |
| op_addr_i | input | ADDR_W-5 (27) | Granule address of the operation, address bits [31:5] |
| snp_valid_i | input | 1 | A system-bus snoop is present this cycle |
| snp_addr_i | input | ADDR_W (32) | Snoop byte address |
| fwd_o | output | 1 | Forward the snoop to the processor (one-cycle strobe) |
| fwd_addr_o | output | ADDR_W (32) | Address of the forwarded snoop |
| upd_valid_o | output | 1 | The directory was written on the previous cycle |
| upd_index_o | output | 4 | Set index of that write |
| upd_bits_o | output | 4 | Flag vector of that set after the write |

## Verification
The hardest case to reach from the ports is a clear and a snoop to the same granule in one cycle, where the snoop must still see the old flag. The stimulus first sets the flag with a read. It then drives an instruction invalidate and a snoop to that granule in the same cycle, and snoops again on the next cycle to confirm the flag is now clear. Tag replacement is reached by reading a conflicting tag into a set that already holds flags, followed by a snoop with the old tag. A long pseudo-random phase then mixes every operation code with snoops over four sets and two tags. A reference model in the bench predicts each outcome.

// File: rtl/ifb_pkg.sv
// Package: shared operation codes for the inclusion-bit snoop filter.
// Assumes a 3-bit processor operation field; codes 5..7 behave as no-ops.
package ifb_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WKILL = 3'd2,
        OP_KILL  = 3'd3,
        OP_ICBI  = 3'd4
    } op_e;

    // True for operations that visibly drop a granule from the L1.
    function automatic logic is_dealloc(op_e op);
        return (op == OP_WKILL) || (op == OP_KILL) || (op == OP_ICBI);
    endfunction

endpackage

// File: rtl/ifb_addr_split.sv
// Module: splits a granule-aligned address into granule, set index and tag.
// Assumes the byte offset inside a granule has already been removed.
module ifb_addr_split #(
    parameter int GA_W   = 27,
    parameter int GRAN_W = 2,
    parameter int IDX_W  = 4,
    localparam int TAG_W = GA_W - GRAN_W - IDX_W
) (
    input  logic [GA_W-1:0]   gaddr_i,
    output logic [GRAN_W-1:0] gran_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o
);

    // Field extraction: granule lowest, then index, then tag.
    always_comb begin
        gran_o = gaddr_i[GRAN_W-1:0];
        idx_o  = gaddr_i[GRAN_W +: IDX_W];
        tag_o  = gaddr_i[GA_W-1 -: TAG_W];
    end

endmodule

// File: rtl/ifb_dir_array.sv
// Module: direct-mapped directory with one write port and two
// combinational read ports (processor side and snoop side).
// Assumes one write per cycle; reads return the pre-write contents.
module ifb_dir_array #(
    parameter int SETS       = 16,
    parameter int TAG_W      = 21,
    parameter int LINE_GRANS = 4,
    localparam int IDX_W     = $clog2(SETS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [TAG_W-1:0]      wr_tag_i,
    input  logic [LINE_GRANS-1:0] wr_bits_i,
    input  logic [IDX_W-1:0]      ra_idx_i,
    output logic                  ra_valid_o,
    output logic [TAG_W-1:0]      ra_tag_o,
    output logic [LINE_GRANS-1:0] ra_bits_o,
    input  logic [IDX_W-1:0]      rb_idx_i,
    output logic                  rb_valid_o,
    output logic [TAG_W-1:0]      rb_tag_o,
    output logic [LINE_GRANS-1:0] rb_bits_o
);

    logic [SETS-1:0]       valid_q;
    logic [TAG_W-1:0]      tag_q  [SETS];
    logic [LINE_GRANS-1:0] bits_q [SETS];

    // Directory state: clear valid and flags on reset, else apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                bits_q[s] <= '0;
                tag_q[s]  <= '0;
            end
        end else if (we_i) begin
            valid_q[wr_idx_i] <= 1'b1;
            tag_q[wr_idx_i]   <= wr_tag_i;
            bits_q[wr_idx_i]  <= wr_bits_i;
        end
    end

    // Read ports: plain multiplexers over the stored entries.
    always_comb begin
        ra_valid_o = valid_q[ra_idx_i];
        ra_tag_o   = tag_q[ra_idx_i];
        ra_bits_o  = bits_q[ra_idx_i];
        rb_valid_o = valid_q[rb_idx_i];
        rb_tag_o   = tag_q[rb_idx_i];
        rb_bits_o  = bits_q[rb_idx_i];
    end

endmodule

// File: rtl/ifb_update_logic.sv
// Module: computes the directory write for one processor operation.
// Reads allocate or replace; deallocating operations clear a flag on a hit only.
module ifb_update_logic
    import ifb_pkg::*;
#(
    parameter int TAG_W      = 21,
    parameter int LINE_GRANS = 4,
    localparam int GRAN_W    = $clog2(LINE_GRANS)
) (
    input  op_e                   op_i,
    input  logic                  ent_valid_i,
    input  logic [TAG_W-1:0]      ent_tag_i,
    input  logic [LINE_GRANS-1:0] ent_bits_i,
    input  logic [TAG_W-1:0]      req_tag_i,
    input  logic [GRAN_W-1:0]     req_gran_i,
    output logic                  we_o,
    output logic [LINE_GRANS-1:0] wr_bits_o
);

    logic                  hit;
    logic [LINE_GRANS-1:0] gran_oh;

    // Hit detection and granule one-hot decode.
    always_comb begin
        hit     = ent_valid_i && (ent_tag_i == req_tag_i);
        gran_oh = '0;
        gran_oh[req_gran_i] = 1'b1;
    end

    // New flag vector and write enable by operation kind.
    always_comb begin
        we_o      = 1'b0;
        wr_bits_o = ent_bits_i;
        if (op_i == OP_READ) begin
            we_o      = 1'b1;
            wr_bits_o = hit ? (ent_bits_i | gran_oh) : gran_oh;
        end else if (is_dealloc(op_i)) begin
            we_o      = hit;
            wr_bits_o = ent_bits_i & ~gran_oh;
        end
    end

endmodule

// File: rtl/ifb_snoop_match.sv
// Module: decides whether a snoop must reach the processor.
// Forwards only on a tag hit whose granule flag is set.
module ifb_snoop_match #(
    parameter int TAG_W      = 21,
    parameter int LINE_GRANS = 4,
    localparam int GRAN_W    = $clog2(LINE_GRANS)
) (
    input  logic                  snp_valid_i,
    input  logic                  ent_valid_i,
    input  logic [TAG_W-1:0]      ent_tag_i,
    input  logic [LINE_GRANS-1:0] ent_bits_i,
    input  logic [TAG_W-1:0]      snp_tag_i,
    input  logic [GRAN_W-1:0]     snp_gran_i,
    output logic                  fwd_o
);

    // Forward decision: valid snoop, tag hit, flag set.
    always_comb begin
        fwd_o = snp_valid_i && ent_valid_i && (ent_tag_i == snp_tag_i)
                && ent_bits_i[snp_gran_i];
    end

endmodule

// File: rtl/ifb_snoop_filter.sv
// Module: top of the inclusion-bit snoop filter. Keeps per-granule L1
// presence flags in a direct-mapped directory and forwards system-bus
// snoops only when a flag is set. All outputs are registered (one cycle).
// Assumes at most one processor operation and one snoop per cycle.
module ifb_snoop_filter
    import ifb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 32,
    parameter int LINE_GRANS = 4,
    parameter int SETS       = 16,
    localparam int OFF_W     = $clog2(GRAN_BYTES),
    localparam int GRAN_W    = $clog2(LINE_GRANS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int GA_W      = ADDR_W - OFF_W,
    localparam int TAG_W     = GA_W - GRAN_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            op_i,
    input  logic [ADDR_W-1:OFF_W] op_addr_i,
    input  logic                  snp_valid_i,
    input  logic [ADDR_W-1:0]     snp_addr_i,
    output logic                  fwd_o,
    output logic [ADDR_W-1:0]     fwd_addr_o,
    output logic                  upd_valid_o,
    output logic [IDX_W-1:0]      upd_index_o,
    output logic [LINE_GRANS-1:0] upd_bits_o
);

    op_e                   op;
    logic [GRAN_W-1:0]     op_gran, sn_gran;
    logic [IDX_W-1:0]      op_idx, sn_idx;
    logic [TAG_W-1:0]      op_tag, sn_tag;
    logic                  opent_valid, snent_valid;
    logic [TAG_W-1:0]      opent_tag, snent_tag;
    logic [LINE_GRANS-1:0] opent_bits, snent_bits;
    logic                  we;
    logic [LINE_GRANS-1:0] wr_bits;
    logic                  fwd_d;

    // Operation code decode into the shared enum.
    always_comb op = op_e'(op_i);

    ifb_addr_split #(.GA_W(GA_W), .GRAN_W(GRAN_W), .IDX_W(IDX_W)) u_op_split (
        .gaddr_i (op_addr_i),
        .gran_o  (op_gran),
        .idx_o   (op_idx),
        .tag_o   (op_tag)
    );

    ifb_addr_split #(.GA_W(GA_W), .GRAN_W(GRAN_W), .IDX_W(IDX_W)) u_sn_split (
        .gaddr_i (snp_addr_i[ADDR_W-1:OFF_W]),
        .gran_o  (sn_gran),
        .idx_o   (sn_idx),
        .tag_o   (sn_tag)
    );

    ifb_dir_array #(.SETS(SETS), .TAG_W(TAG_W), .LINE_GRANS(LINE_GRANS)) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (we),
        .wr_idx_i   (op_idx),
        .wr_tag_i   (op_tag),
        .wr_bits_i  (wr_bits),
        .ra_idx_i   (op_idx),
        .ra_valid_o (opent_valid),
        .ra_tag_o   (opent_tag),
        .ra_bits_o  (opent_bits),
        .rb_idx_i   (sn_idx),
        .rb_valid_o (snent_valid),
        .rb_tag_o   (snent_tag),
        .rb_bits_o  (snent_bits)
    );

    ifb_update_logic #(.TAG_W(TAG_W), .LINE_GRANS(LINE_GRANS)) u_upd (
        .op_i        (op),
        .ent_valid_i (opent_valid),
        .ent_tag_i   (opent_tag),
        .ent_bits_i  (opent_bits),
        .req_tag_i   (op_tag),
        .req_gran_i  (op_gran),
        .we_o        (we),
        .wr_bits_o   (wr_bits)
    );

    ifb_snoop_match #(.TAG_W(TAG_W), .LINE_GRANS(LINE_GRANS)) u_match (
        .snp_valid_i (snp_valid_i),
        .ent_valid_i (snent_valid),
        .ent_tag_i   (snent_tag),
        .ent_bits_i  (snent_bits),
        .snp_tag_i   (sn_tag),
        .snp_gran_i  (sn_gran),
        .fwd_o       (fwd_d)
    );

    // Output stage: register the forward strobe and the update report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_o       <= 1'b0;
            fwd_addr_o  <= '0;
            upd_valid_o <= 1'b0;
            upd_index_o <= '0;
            upd_bits_o  <= '0;
        end else begin
            fwd_o       <= fwd_d;
            upd_valid_o <= we;
            if (fwd_d) fwd_addr_o <= snp_addr_i;
            if (we) begin
                upd_index_o <= op_idx;
                upd_bits_o  <= wr_bits;
            end
        end
    end

endmodule

// File: rtl/ifb_snoop_filter_chk.sv
// Checker: temporal properties of the snoop filter ports, bound to the top.
// Assumes the default field layout passed in through parameters.
module ifb_snoop_filter_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_GRANS = 4,
    parameter int GRAN_W     = 2,
    parameter int IDX_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [2:0]            op_i,
    input logic [GRAN_W-1:0]     op_gran,
    input logic [IDX_W-1:0]      op_idx,
    input logic                  snp_valid_i,
    input logic [ADDR_W-1:0]     snp_addr_i,
    input logic                  fwd_o,
    input logic [ADDR_W-1:0]     fwd_addr_o,
    input logic                  upd_valid_o,
    input logic [IDX_W-1:0]      upd_index_o,
    input logic [LINE_GRANS-1:0] upd_bits_o
);

    logic seen_q = 1'b0;

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) seen_q <= 1'b1;

    p_reset_quiet_r1: assert property (@(posedge clk)
        (seen_q && !$past(rst_n)) |-> (!fwd_o && !upd_valid_o));

    p_fwd_needs_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_o |-> ($past(snp_valid_i) && fwd_addr_o == $past(snp_addr_i)));

    p_read_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == 3'd1) |->
        (upd_valid_o && upd_bits_o[$past(op_gran)] && upd_index_o == $past(op_idx)));

    p_wkill_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && $past(op_i) == 3'd2) |-> !upd_bits_o[$past(op_gran)]);

    p_kill_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && $past(op_i) == 3'd3) |-> !upd_bits_o[$past(op_gran)]);

    p_icbi_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_o && $past(op_i) == 3'd4) |-> !upd_bits_o[$past(op_gran)]);

    p_upd_needs_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> ($past(op_i) != 3'd0 && $past(op_i) <= 3'd4));

endmodule

bind ifb_snoop_filter ifb_snoop_filter_chk #(
    .ADDR_W(ADDR_W), .LINE_GRANS(LINE_GRANS), .GRAN_W(GRAN_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .op_gran     (op_gran),
    .op_idx      (op_idx),
    .snp_valid_i (snp_valid_i),
    .snp_addr_i  (snp_addr_i),
    .fwd_o       (fwd_o),
    .fwd_addr_o  (fwd_addr_o),
    .upd_valid_o (upd_valid_o),
    .upd_index_o (upd_index_o),
    .upd_bits_o  (upd_bits_o)
);

// File: tb/tb_ifb_snoop_filter.sv
// Scoreboard bench: the driver predicts each cycle's outputs from a model
// and queues them; the monitor compares one item per clock edge.
module tb_ifb_snoop_filter;

    localparam int ADDR_W = 32;
    localparam int LG     = 4;
    localparam int SETS   = 16;
    localparam int OFF_W  = 5;
    localparam int GRAN_W = 2;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = ADDR_W - OFF_W - GRAN_W - IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        op_i = '0;
    logic [ADDR_W-1:0] op_full = '0;
    logic              snp_valid_i = 1'b0;
    logic [ADDR_W-1:0] snp_addr_i = '0;
    logic              fwd_o;
    logic [ADDR_W-1:0] fwd_addr_o;
    logic              upd_valid_o;
    logic [IDX_W-1:0]  upd_index_o;
    logic [LG-1:0]     upd_bits_o;

    always #2 clk = ~clk;

    ifb_snoop_filter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .op_addr_i   (op_full[ADDR_W-1:OFF_W]),
        .snp_valid_i (snp_valid_i),
        .snp_addr_i  (snp_addr_i),
        .fwd_o       (fwd_o),
        .fwd_addr_o  (fwd_addr_o),
        .upd_valid_o (upd_valid_o),
        .upd_index_o (upd_index_o),
        .upd_bits_o  (upd_bits_o)
    );

    typedef struct {
        logic              fwd;
        logic [ADDR_W-1:0] fa;
        logic              uv;
        logic [IDX_W-1:0]  ui;
        logic [LG-1:0]     ub;
        string             req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    logic             m_v [SETS];
    logic [TAG_W-1:0] m_t [SETS];
    logic [LG-1:0]    m_b [SETS];

    function automatic logic [ADDR_W-1:0] mk(int tag, int idx, int g, int off);
        logic [ADDR_W-1:0] a;
        a = '0;
        a[OFF_W-1:0]               = OFF_W'(off);
        a[OFF_W +: GRAN_W]         = GRAN_W'(g);
        a[OFF_W+GRAN_W +: IDX_W]   = IDX_W'(idx);
        a[ADDR_W-1 -: TAG_W]       = TAG_W'(tag);
        return a;
    endfunction

    // Driver: apply inputs on the falling edge and queue the prediction.
    task automatic drive(input logic [2:0] op, input logic [ADDR_W-1:0] oa,
                         input logic sv, input logic [ADDR_W-1:0] sa, input string req);
        exp_t e;
        int oi, og, si, sg;
        logic [TAG_W-1:0] ot, st;
        logic [LG-1:0] oh;
        @(negedge clk);
        op_i = op; op_full = oa; snp_valid_i = sv; snp_addr_i = sa;
        oi = int'(oa[OFF_W+GRAN_W +: IDX_W]); og = int'(oa[OFF_W +: GRAN_W]);
        ot = oa[ADDR_W-1 -: TAG_W];
        si = int'(sa[OFF_W+GRAN_W +: IDX_W]); sg = int'(sa[OFF_W +: GRAN_W]);
        st = sa[ADDR_W-1 -: TAG_W];
        e.req = req;
        e.fwd = sv && m_v[si] && m_t[si] == st && m_b[si][sg];
        e.fa  = sa;
        e.uv = 1'b0; e.ui = '0; e.ub = '0;
        oh = '0; oh[og] = 1'b1;
        if (op == 3'd1) begin
            if (!(m_v[oi] && m_t[oi] == ot)) m_b[oi] = '0;
            m_v[oi] = 1'b1; m_t[oi] = ot; m_b[oi] = m_b[oi] | oh;
            e.uv = 1'b1; e.ui = IDX_W'(oi); e.ub = m_b[oi];
        end else if (op >= 3'd2 && op <= 3'd4 && m_v[oi] && m_t[oi] == ot) begin
            m_b[oi] = m_b[oi] & ~oh;
            e.uv = 1'b1; e.ui = IDX_W'(oi); e.ub = m_b[oi];
        end
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        drive(3'd0, '0, 1'b0, '0, req);
    endtask

    task automatic snoop(input logic [ADDR_W-1:0] sa, input string req);
        drive(3'd0, '0, 1'b1, sa, req);
    endtask

    task automatic oper(input logic [2:0] op, input logic [ADDR_W-1:0] oa, input string req);
        drive(op, oa, 1'b0, '0, req);
    endtask

    // Monitor: after each rising edge, pop one prediction and compare.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (fwd_o !== e.fwd || (e.fwd && fwd_addr_o !== e.fa) ||
                upd_valid_o !== e.uv ||
                (e.uv && (upd_index_o !== e.ui || upd_bits_o !== e.ub))) begin
                fails++;
                $display("FAIL %s: got fwd=%b fa=%h uv=%b ui=%0d ub=%b, expected fwd=%b fa=%h uv=%b ui=%0d ub=%b",
                         e.req, fwd_o, fwd_addr_o, upd_valid_o, upd_index_o, upd_bits_o,
                         e.fwd, e.fa, e.uv, e.ui, e.ub);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++) begin
            m_v[s] = 1'b0; m_t[s] = '0; m_b[s] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        checks++;
        if (fwd_o !== 1'b0 || upd_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1: got fwd=%b uv=%b, expected 0 0", fwd_o, upd_valid_o);
        end
        rst_n = 1'b1;
        snoop(mk(1, 2, 1, 0), "R1");             // empty directory
        oper(3'd1, mk(1, 2, 1, 0), "R2");        // bits 0010
        snoop(mk(1, 2, 1, 0), "R9");
        idle("R9");                              // single pulse
        snoop(mk(1, 2, 1, 31), "R12");           // byte offset ignored
        snoop(mk(1, 2, 2, 0), "R8");
        snoop(mk(2, 2, 1, 0), "R7");             // tag mismatch
        snoop(mk(1, 3, 1, 0), "R7");             // invalid set
        oper(3'd1, mk(1, 2, 3, 0), "R6");        // bits 1010
        oper(3'd2, mk(1, 2, 1, 0), "R3");        // bits 1000
        snoop(mk(1, 2, 1, 0), "R3");
        oper(3'd3, mk(1, 2, 3, 0), "R4");        // bits 0000
        snoop(mk(1, 2, 3, 0), "R4");
        oper(3'd1, mk(1, 2, 0, 0), "R2");
        oper(3'd4, mk(1, 2, 0, 0), "R5");
        snoop(mk(1, 2, 0, 0), "R5");
        oper(3'd1, mk(1, 2, 2, 0), "R2");        // bits 0100
        oper(3'd2, mk(5, 2, 2, 0), "R10");       // clear misses
        oper(3'd3, mk(1, 9, 2, 0), "R10");       // clear to invalid set
        snoop(mk(1, 2, 2, 0), "R10");            // flag survived
        drive(3'd4, mk(1, 2, 2, 0), 1'b1, mk(1, 2, 2, 7), "R11");
        snoop(mk(1, 2, 2, 0), "R11");
        oper(3'd1, mk(1, 5, 0, 0), "R2");
        oper(3'd1, mk(1, 5, 1, 0), "R6");        // bits 0011
        oper(3'd1, mk(7, 5, 2, 0), "R2");        // replace: bits 0100
        snoop(mk(1, 5, 0, 0), "R7");
        snoop(mk(7, 5, 2, 0), "R9");
        drive(3'd1, mk(3, 7, 3, 0), 1'b1, mk(7, 5, 2, 4), "R9");
        idle("R12");                             // code 0 does nothing
        begin
            logic [31:0] lf;
            lf = 32'h1ACE_5EED;
            for (int i = 0; i < 400; i++) begin
                logic [2:0] op;
                lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                op = 3'(lf[2:0] % 5);
                drive(op, mk(int'(lf[3]), int'(lf[5:4]), int'(lf[7:6]), int'(lf[12:8])),
                      lf[13], mk(int'(lf[14]), int'(lf[16:15]), int'(lf[18:17]), int'(lf[23:19])),
                      lf[13] ? "R9" : (op == 3'd1 ? "R2" : "R10"));
            end
        end
        idle("R13");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule